// File: doc/BRIEF.md
# Sleep Mode Clock Gating Controller

This block is the power manager of a small microcontroller. Software picks one of six low-power modes with a 3-bit code and then pulses a sleep request. The controller samples the code, gates the clock domains that the chosen mode stops, and holds that state until a wake source whose domain still has a clock fires. It drives five registered enables: the CPU clock, the I/O clock (SRAM, timers, SPI, interrupt logic), the ADC clock, the asynchronous timer clock and the main oscillator.

Two of the modes stop the main oscillator: the deep power-off mode and the power-save mode. Waking from either one passes through a warm-up phase. In that phase the oscillator runs while the CPU stays gated. The phase ends when the oscillator reports it is ready, or when a start-up count runs out, whichever happens first. Every other mode returns to full operation one cycle after the wake is seen. Synchronous reset always brings the block back to full operation.

Top module: `sleep_clkgate_ctrl`

## Requirements
- R1: After reset, all five enables are 1 and `mode_o` is 0.
- R2: The mode codes are 1 idle, 2 ADC-quiet, 3 power-off, 4 power-save, 5 standby and 6 extended standby. A sleep request with code 0 or 7 is ignored: all enables stay 1 and `mode_o` stays 0.
- R3: A sleep request with a valid code that is sampled in the running state loads the enables for that mode and sets `mode_o` to the code. Both take effect at the same clock edge, so they are visible one cycle later.
- R4: The enables in each sleep mode, as {cpu,io,adc,atmr,osc}: idle 01111, ADC-quiet 00111, power-off 00000, power-save 00010, standby 00001, extended standby 00011.
- R5: `ext_irq` wakes the block from every sleep mode.
- R6: `periph_irq`, `atmr_evt` and `adc_done` wake the block only while the io, atmr and adc enable respectively is 1. Otherwise the enables and `mode_o` stay unchanged.
- R7: A wake from idle, ADC-quiet, standby or extended standby sets all enables to 1 and `mode_o` to 0 one cycle after the wake is sampled.
- R8: A wake from power-off or power-save enters warm-up. In warm-up `osc_en` is 1, `atmr_clk_en` keeps its value from the mode, cpu, io and adc are 0, and `mode_o` keeps the code.
- R9: If `osc_rdy` is sampled high during warm-up, all enables are 1 and `mode_o` is 0 one cycle later.
- R10: Without `osc_rdy`, warm-up lasts max(`startup_lim`,1) cycles before all enables return to 1.
- R11: A sleep request is ignored while the block sleeps or warms up. Wake inputs are ignored while it runs, so a sleep request that coincides with a wake pulse still enters sleep.
- R12: Reset during sleep or warm-up returns the block to the state of R1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset (hardware reset) |
| mode_sel | input | 3 | Requested sleep mode code |
| sleep_req | input | 1 | Sleep request strobe |
| ext_irq | input | 1 | External interrupt wake source |
| periph_irq | input | 1 | Peripheral interrupt wake source (I/O domain) |
| atmr_evt | input | 1 | Asynchronous timer event wake source |
| adc_done | input | 1 | ADC conversion complete wake source |
| osc_rdy | input | 1 | Main oscillator stable indication |
| startup_lim | input | CNT_W | Warm-up length in cycles |
| cpu_clk_en | output | 1 | CPU clock enable |
| io_clk_en | output | 1 | I/O peripheral clock enable |
| adc_clk_en | output | 1 | ADC clock enable |
| atmr_clk_en | output | 1 | Asynchronous timer clock enable |
| osc_en | output | 1 | Main oscillator enable |
| mode_o | output | 3 | Current sleep mode code, 0 while running |

## Verification
Two functions can meet in one cycle. A sleep request and a wake pulse can arrive together while the block runs, and `osc_rdy` can rise while a wake from a gated mode is still being served. The bench drives `ext_irq` in the same cycle as a power-off sleep request and expects the power-off enables, not a stay in the running state. It then pulses `osc_rdy` early in warm-up and expects full operation exactly one cycle later, well before the start-up count would expire. Every mode code is crossed with every wake source, and the expected result is taken from the enable table and the domain rule.

// File: rtl/slp_pkg.sv
package slp_pkg;
  localparam logic [2:0] M_NONE  = 3'd0;
  localparam logic [2:0] M_IDLE  = 3'd1;
  localparam logic [2:0] M_ADCQ  = 3'd2;
  localparam logic [2:0] M_PDOWN = 3'd3;
  localparam logic [2:0] M_PSAVE = 3'd4;
  localparam logic [2:0] M_STBY  = 3'd5;
  localparam logic [2:0] M_XSTBY = 3'd6;

  typedef struct packed {
    logic cpu;
    logic io;
    logic adc;
    logic atmr;
    logic osc;
  } clk_en_t;

  localparam clk_en_t EN_ALL  = '{cpu: 1'b1, io: 1'b1, adc: 1'b1, atmr: 1'b1, osc: 1'b1};
  localparam clk_en_t EN_NONE = '{cpu: 1'b0, io: 1'b0, adc: 1'b0, atmr: 1'b0, osc: 1'b0};

  typedef enum logic [1:0] {ST_RUN, ST_SLEEP, ST_WARM} slp_state_e;

  function automatic logic mode_valid(input logic [2:0] m);
    return (m != 3'd0) && (m != 3'd7);
  endfunction

  function automatic logic osc_stops(input logic [2:0] m);
    return (m == M_PDOWN) || (m == M_PSAVE);
  endfunction
endpackage

// File: rtl/slp_mode_table.sv
module slp_mode_table
  import slp_pkg::*;
(
  input  logic [2:0] mode,
  output clk_en_t    sleep_en,
  output clk_en_t    warm_en
);
  always_comb begin
    sleep_en = EN_NONE;
    unique case (mode)
      M_IDLE:  sleep_en = '{cpu: 1'b0, io: 1'b1, adc: 1'b1, atmr: 1'b1, osc: 1'b1};
      M_ADCQ:  sleep_en = '{cpu: 1'b0, io: 1'b0, adc: 1'b1, atmr: 1'b1, osc: 1'b1};
      M_PDOWN: sleep_en = EN_NONE;
      M_PSAVE: sleep_en = '{cpu: 1'b0, io: 1'b0, adc: 1'b0, atmr: 1'b1, osc: 1'b0};
      M_STBY:  sleep_en = '{cpu: 1'b0, io: 1'b0, adc: 1'b0, atmr: 1'b0, osc: 1'b1};
      M_XSTBY: sleep_en = '{cpu: 1'b0, io: 1'b0, adc: 1'b0, atmr: 1'b1, osc: 1'b1};
      default: sleep_en = EN_ALL;
    endcase
  end

  always_comb begin
    warm_en      = sleep_en;
    warm_en.osc  = 1'b1;
    warm_en.cpu  = 1'b0;
    warm_en.io   = 1'b0;
    warm_en.adc  = 1'b0;
  end
endmodule

// File: rtl/slp_wake_filter.sv
module slp_wake_filter
  import slp_pkg::*;
(
  input  logic    ext_irq,
  input  logic    periph_irq,
  input  logic    atmr_evt,
  input  logic    adc_done,
  input  clk_en_t cur_en,
  output logic    wake
);
  always_comb begin
    wake = ext_irq
         | (periph_irq & cur_en.io)
         | (atmr_evt   & cur_en.atmr)
         | (adc_done   & cur_en.adc);
  end
endmodule

// File: rtl/slp_warmup_timer.sv
module slp_warmup_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             run,
  input  logic [CNT_W-1:0] lim,
  output logic             done
);
  localparam int XW = CNT_W + 1;

  logic [CNT_W-1:0] cnt_q;
  logic [XW-1:0]    cnt_nx;

  assign cnt_nx = {1'b0, cnt_q} + XW'(1);
  assign done   = run && (cnt_nx >= {1'b0, lim});

  always_ff @(posedge clk) begin
    if (rst || start) begin
      cnt_q <= '0;
    end else if (run && !done) begin
      cnt_q <= cnt_nx[CNT_W-1:0];
    end
  end

  // R10
  cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
    run |-> (cnt_q == '0 || cnt_q < lim));
endmodule

// File: rtl/sleep_clkgate_ctrl.sv
module sleep_clkgate_ctrl
  import slp_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [2:0]       mode_sel,
  input  logic             sleep_req,
  input  logic             ext_irq,
  input  logic             periph_irq,
  input  logic             atmr_evt,
  input  logic             adc_done,
  input  logic             osc_rdy,
  input  logic [CNT_W-1:0] startup_lim,
  output logic             cpu_clk_en,
  output logic             io_clk_en,
  output logic             adc_clk_en,
  output logic             atmr_clk_en,
  output logic             osc_en,
  output logic [2:0]       mode_o
);
  slp_state_e state_q, state_d;
  logic [2:0] mode_q, mode_d;
  clk_en_t    en_q, en_d, tbl_sleep, tbl_warm;
  logic       wake, tmr_start, tmr_done;

  slp_mode_table u_table (
    .mode     (mode_d),
    .sleep_en (tbl_sleep),
    .warm_en  (tbl_warm)
  );

  slp_wake_filter u_wake (
    .ext_irq    (ext_irq),
    .periph_irq (periph_irq),
    .atmr_evt   (atmr_evt),
    .adc_done   (adc_done),
    .cur_en     (en_q),
    .wake       (wake)
  );

  slp_warmup_timer #(.CNT_W(CNT_W)) u_timer (
    .clk   (clk),
    .rst   (rst),
    .start (tmr_start),
    .run   (state_q == ST_WARM),
    .lim   (startup_lim),
    .done  (tmr_done)
  );

  always_comb begin
    state_d   = state_q;
    mode_d    = mode_q;
    tmr_start = 1'b0;
    unique case (state_q)
      ST_RUN: begin
        if (sleep_req && mode_valid(mode_sel)) begin
          state_d = ST_SLEEP;
          mode_d  = mode_sel;
        end
      end
      ST_SLEEP: begin
        if (wake) begin
          if (osc_stops(mode_q)) begin
            state_d   = ST_WARM;
            tmr_start = 1'b1;
          end else begin
            state_d = ST_RUN;
            mode_d  = M_NONE;
          end
        end
      end
      ST_WARM: begin
        if (osc_rdy || tmr_done) begin
          state_d = ST_RUN;
          mode_d  = M_NONE;
        end
      end
      default: begin
        state_d = ST_RUN;
        mode_d  = M_NONE;
      end
    endcase
  end

  always_comb begin
    unique case (state_d)
      ST_SLEEP: en_d = tbl_sleep;
      ST_WARM:  en_d = tbl_warm;
      default:  en_d = EN_ALL;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_RUN;
      mode_q  <= M_NONE;
      en_q    <= EN_ALL;
    end else begin
      state_q <= state_d;
      mode_q  <= mode_d;
      en_q    <= en_d;
    end
  end

  assign cpu_clk_en  = en_q.cpu;
  assign io_clk_en   = en_q.io;
  assign adc_clk_en  = en_q.adc;
  assign atmr_clk_en = en_q.atmr;
  assign osc_en      = en_q.osc;
  assign mode_o      = mode_q;

  // R3
  entry_mode_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_RUN && sleep_req && mode_valid(mode_sel)) |=> (mode_o == $past(mode_sel) && !cpu_clk_en));

  // R8
  warm_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_WARM) |-> (osc_en && !cpu_clk_en && !io_clk_en && mode_o != M_NONE));

  // R7
  quick_wake_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_SLEEP && ext_irq && !osc_stops(mode_q)) |=> (cpu_clk_en && mode_o == M_NONE));

  // R6
  pdown_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_SLEEP && mode_q == M_PDOWN && !ext_irq) |=> (state_q == ST_SLEEP && !osc_en));

  // R11
  run_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_RUN && !sleep_req) |=> (state_q == ST_RUN && cpu_clk_en));
endmodule

// File: tb/sleep_clkgate_ctrl_bench.sv
module sleep_clkgate_ctrl_bench;
  localparam int CNT_W = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [2:0] mode_sel = 3'd0;
  logic sleep_req = 1'b0, ext_irq = 1'b0, periph_irq = 1'b0, atmr_evt = 1'b0, adc_done = 1'b0, osc_rdy = 1'b0;
  logic [CNT_W-1:0] startup_lim = 16'd3;
  logic cpu_clk_en, io_clk_en, adc_clk_en, atmr_clk_en, osc_en;
  logic [2:0] mode_o;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  sleep_clkgate_ctrl #(.CNT_W(CNT_W)) u_sleep_clkgate_ctrl (
    .clk(clk), .rst(rst), .mode_sel(mode_sel), .sleep_req(sleep_req),
    .ext_irq(ext_irq), .periph_irq(periph_irq), .atmr_evt(atmr_evt), .adc_done(adc_done),
    .osc_rdy(osc_rdy), .startup_lim(startup_lim),
    .cpu_clk_en(cpu_clk_en), .io_clk_en(io_clk_en), .adc_clk_en(adc_clk_en),
    .atmr_clk_en(atmr_clk_en), .osc_en(osc_en), .mode_o(mode_o)
  );

  function automatic logic [4:0] got_en();
    return {cpu_clk_en, io_clk_en, adc_clk_en, atmr_clk_en, osc_en};
  endfunction

  function automatic bit valid_code(int m);
    return m >= 1 && m <= 6;
  endfunction

  function automatic logic [4:0] exp_sleep(int m);
    case (m)
      1: return 5'b01111;
      2: return 5'b00111;
      3: return 5'b00000;
      4: return 5'b00010;
      5: return 5'b00001;
      6: return 5'b00011;
      default: return 5'b11111;
    endcase
  endfunction

  function automatic logic [4:0] exp_warm(int m);
    return {3'b000, exp_sleep(m)[1], 1'b1};
  endfunction

  task automatic check(string req, int got, int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s got=%0h exp=%0h", req, got, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; sleep_req = 0; ext_irq = 0; periph_irq = 0; atmr_evt = 0; adc_done = 0; osc_rdy = 0;
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic enter(int m);
    @(negedge clk);
    mode_sel = 3'(m); sleep_req = 1'b1;
    @(negedge clk);
    sleep_req = 1'b0;
  endtask

  task automatic set_wake(int w, logic v);
    case (w)
      1: ext_irq = v;
      2: periph_irq = v;
      3: atmr_evt = v;
      4: adc_done = v;
      default: ;
    endcase
  endtask

  task automatic pulse_wake(int w);
    @(negedge clk);
    set_wake(w, 1'b1);
    @(negedge clk);
    set_wake(w, 1'b0);
  endtask

  function automatic bit qualifies(int w, logic [4:0] en);
    case (w)
      1: return 1'b1;
      2: return en[3];
      3: return en[1];
      4: return en[2];
      default: return 1'b0;
    endcase
  endfunction

  initial begin
    do_reset();
    // R1
    check("R1 enables", got_en(), 5'b11111);
    check("R1 mode", mode_o, 0);

    // full sweep: every code against every wake source
    for (int m = 0; m < 8; m++) begin
      for (int w = 0; w < 5; w++) begin
        do_reset();
        startup_lim = 16'd3;
        enter(m);
        check(valid_code(m) ? "R3 R4 entry enables" : "R2 unused code enables", got_en(), exp_sleep(m));
        check(valid_code(m) ? "R3 entry mode" : "R2 unused code mode", mode_o, valid_code(m) ? m : 0);
        pulse_wake(w);
        if (!valid_code(m)) begin
          check("R11 wake ignored while running", got_en(), 5'b11111);
        end else if (!qualifies(w, exp_sleep(m))) begin
          check("R6 unqualified wake enables", got_en(), exp_sleep(m));
          check("R6 unqualified wake mode", mode_o, m);
        end else if (m == 3 || m == 4) begin
          check("R8 warm-up enables", got_en(), exp_warm(m));
          check("R8 warm-up mode", mode_o, m);
          for (int k = 1; k < 3; k++) begin
            @(negedge clk);
            check("R10 cpu still gated", cpu_clk_en, 0);
          end
          @(negedge clk);
          check("R10 warm-up end enables", got_en(), 5'b11111);
          check("R10 warm-up end mode", mode_o, 0);
        end else begin
          check(w == 1 ? "R5 R7 wake enables" : "R7 wake enables", got_en(), 5'b11111);
          check("R7 wake mode", mode_o, 0);
        end
      end
    end

    // R10: warm-up length for several limits, including 0
    for (int li = 0; li < 4; li++) begin
      int lim_v;
      int len;
      lim_v = (li == 0) ? 0 : (li == 1) ? 1 : (li == 2) ? 2 : 6;
      do_reset();
      startup_lim = 16'(lim_v);
      enter(4);
      pulse_wake(3);
      len = 0;
      for (int k = 0; k < 20 && !cpu_clk_en; k++) begin
        @(negedge clk);
        len++;
      end
      check("R10 warm-up length", len, (lim_v < 1) ? 1 : lim_v);
    end

    // R9: oscillator ready ends warm-up early
    do_reset();
    startup_lim = 16'd40;
    enter(3);
    pulse_wake(1);
    @(negedge clk);
    check("R9 still warming", cpu_clk_en, 0);
    osc_rdy = 1'b1;
    @(negedge clk);
    osc_rdy = 1'b0;
    check("R9 osc ready enables", got_en(), 5'b11111);
    check("R9 osc ready mode", mode_o, 0);

    // R11: sleep request with wake pulse in same cycle while running
    do_reset();
    @(negedge clk);
    mode_sel = 3'd3; sleep_req = 1'b1; ext_irq = 1'b1;
    @(negedge clk);
    sleep_req = 1'b0; ext_irq = 1'b0;
    check("R11 sleep wins over wake", got_en(), exp_sleep(3));
    check("R11 sleep wins mode", mode_o, 3);

    // R11: sleep request ignored while sleeping and during warm-up
    do_reset();
    startup_lim = 16'd5;
    enter(1);
    enter(5);
    check("R11 sleep req while asleep mode", mode_o, 1);
    check("R11 sleep req while asleep enables", got_en(), exp_sleep(1));
    do_reset();
    enter(4);
    pulse_wake(1);
    enter(2);
    check("R11 sleep req during warm-up mode", mode_o, 4);
    check("R11 sleep req during warm-up enables", got_en(), exp_warm(4));

    // R12: reset from sleep and from warm-up
    do_reset();
    enter(3);
    do_reset();
    check("R12 reset from sleep enables", got_en(), 5'b11111);
    check("R12 reset from sleep mode", mode_o, 0);
    startup_lim = 16'd30;
    enter(4);
    pulse_wake(1);
    do_reset();
    check("R12 reset from warm-up enables", got_en(), 5'b11111);
    check("R12 reset from warm-up mode", mode_o, 0);

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog got=hung exp=done");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule